// File: doc/BRIEF.md
# Configurable Header Key Extractor

This block builds the search keys for one match stage of a packet-processing pipeline. The incoming header vector is a 512-bit word made of typed containers: eight of 8 bits, eight of 16 bits, eight of 32 bits and a single 64-bit container. Two keys come out of every stage. One goes to the exact-match table and one goes to the ternary table. Each key is assembled from up to four sub-fields, and software picks every sub-field at runtime by naming a container, a start bit and a bit count.

The selected sub-fields are right-aligned and then joined in two levels of pairwise merges. Each merge drops the unused bits of its inputs and stacks the second operand directly above the valid bits of the first. Every merge also produces a contiguous mask that marks the valid key bits, so the lookup stage can compare keys of any length. The configuration is written through a narrow write port before traffic starts. It stays in place until reset or until it is written again.

Top module: `kx_key_extractor`

## Requirements
- R1: Header vector layout. The 8-bit container i occupies bits [8i+7:8i]. The 16-bit container i occupies bits [64+16i+15:64+16i]. The 32-bit container i occupies bits [192+32i+31:192+32i]. The 64-bit container occupies bits [511:448].
- R2: A configuration write happens when `cfg_wr` is high at a clock edge. `cfg_key` selects the key (0 = exact, 1 = ternary). `cfg_slot` selects the slot (0..3). `cfg_field` is {type[16:15], index[14:12], start[11:6], length[5:0]}, where type 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit, and the index is ignored for type 3. A write applies to every header vector sampled at a later edge.
- R3: When `phv_valid` is high at an edge, both `em_valid` and `tc_valid` are high for exactly the following cycle. Otherwise they are low.
- R4: A slot extracts container bits [start+length-1:start], right-aligned, with bit `start` landing in the lowest position.
- R5: Slot 0 sits at key bit 0. Each later slot is packed directly above the valid bits of the slots before it. The mask has ones exactly over the total valid length, and all key and mask bits above that length are zero.
- R6: A slot with length 0 contributes nothing. A key whose four slots all have length 0 is all zeros with an all-zero mask.
- R7: A length above 32 is treated as 32. Bits past the top of the container are dropped, so a start at or beyond the container width yields an empty field.
- R8: After reset, the valid flags, keys and masks are zero and every slot is disabled.
- R9: In a cycle after one without `phv_valid`, the keys and masks keep their previous values.
- R10: The two keys are configured and built independently. Writing one key's slots never changes the other key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phv_valid | input | 1 | Header vector strobe |
| phv_data | input | 512 | Header vector |
| cfg_wr | input | 1 | Slot configuration write enable |
| cfg_key | input | 1 | Key select: 0 exact, 1 ternary |
| cfg_slot | input | 2 | Slot select |
| cfg_field | input | 17 | Slot descriptor {type, index, start, length} |
| em_key | output | 128 | Exact-match key |
| em_mask | output | 128 | Exact-match valid-bit mask |
| em_valid | output | 1 | Exact-match key valid |
| tc_key | output | 128 | Ternary key |
| tc_mask | output | 128 | Ternary valid-bit mask |
| tc_valid | output | 1 | Ternary key valid |

## Verification
The bench uses the default build: eight containers of each narrow type and 32-bit fields. With those values a single key can reach the full 128-bit width when four 32-bit fields are chained, and the 64-bit container can push a start past the 32-bit field limit. Under that build the bench covers truncation at every container width, clamping of lengths, empty slots between live ones, and the all-ones mask. A behavioural bit-by-bit model predicts both keys on every cycle, including cycles where the strobe is idle and configuration is rewritten between header vectors.

// File: rtl/kx_pkg.sv
// Shared constants and types for the header key extractor.
// Assumes the container counts of each narrow type are equal and a power of two.
package kx_pkg;
    localparam int IDX_W  = 3;
    localparam int POS_W  = 6;
    localparam int LEN_W  = 6;
    localparam int N_CONT = 1 << IDX_W;
    localparam int OFF16  = N_CONT * 8;
    localparam int OFF32  = OFF16 + N_CONT * 16;
    localparam int OFF64  = OFF32 + N_CONT * 32;
    localparam int PHV_W  = OFF64 + 64;

    typedef enum logic [1:0] {CT_B8, CT_B16, CT_B32, CT_B64} ctype_e;

    typedef struct packed {
        ctype_e             ctype;
        logic [IDX_W-1:0]   idx;
        logic [POS_W-1:0]   start;
        logic [LEN_W-1:0]   len;
    } fld_cfg_t;

    localparam int CFG_W = $bits(fld_cfg_t);
endpackage

// File: rtl/kx_field_select.sv
// Picks one container from the header vector and cuts out a right-aligned
// sub-field. The length is clamped to FLD_W and truncated at the container edge.
// Outputs the field, its valid-bit mask and its effective length.
// Assumes FLD_W <= 64 and FLD_W < 2**LEN_W.
module kx_field_select
    import kx_pkg::*;
#(
    parameter int FLD_W = 32
) (
    input  logic [PHV_W-1:0] phv,
    input  fld_cfg_t         cfg,
    output logic [FLD_W-1:0] fld,
    output logic [FLD_W-1:0] fmask,
    output logic [LEN_W-1:0] flen
);
    localparam logic [LEN_W-1:0] FLD_MAX = LEN_W'(FLD_W);

    logic [63:0]      cont;
    logic [6:0]       cw;
    logic [6:0]       avail;
    logic [LEN_W-1:0] req;
    logic [LEN_W-1:0] eff;
    logic [63:0]      shifted;
    logic [63:0]      wide_mask;

    // Container multiplexer: zero-extended container and its width.
    always_comb begin
        case (cfg.ctype)
            CT_B8:  begin cont = 64'(phv[int'(cfg.idx) * 8 +: 8]);          cw = 7'd8;  end
            CT_B16: begin cont = 64'(phv[OFF16 + int'(cfg.idx) * 16 +: 16]); cw = 7'd16; end
            CT_B32: begin cont = 64'(phv[OFF32 + int'(cfg.idx) * 32 +: 32]); cw = 7'd32; end
            default: begin cont = phv[OFF64 +: 64];                        cw = 7'd64; end
        endcase
    end

    // Effective length: clamp to FLD_W, then truncate at the container edge.
    always_comb begin
        avail = ({1'b0, cfg.start} < cw) ? (cw - {1'b0, cfg.start}) : 7'd0;
        req   = (cfg.len > FLD_MAX) ? FLD_MAX : cfg.len;
        eff   = (avail < 7'(req)) ? avail[LEN_W-1:0] : req;
    end

    // Shift down to bit 0 and keep only the effective length.
    always_comb begin
        shifted   = cont >> cfg.start;
        wide_mask = ~(64'hFFFF_FFFF_FFFF_FFFF << eff);
        fmask     = wide_mask[FLD_W-1:0];
        fld       = shifted[FLD_W-1:0] & fmask;
        flen      = eff;
    end
endmodule

// File: rtl/kx_resizer.sv
// Pairwise merge. Operand b is stacked directly above the la valid bits of
// operand a, and the masks are merged the same way. Assumes both operands are
// already zero above their valid bits.
module kx_resizer #(
    parameter int IN_W = 32,
    parameter int SH_W = 6
) (
    input  logic [IN_W-1:0]   a,
    input  logic [IN_W-1:0]   ma,
    input  logic [SH_W-1:0]   la,
    input  logic [IN_W-1:0]   b,
    input  logic [IN_W-1:0]   mb,
    output logic [2*IN_W-1:0] y,
    output logic [2*IN_W-1:0] m
);
    // Concatenate the valid parts and their masks.
    always_comb begin
        y = {{IN_W{1'b0}}, a}  | ({{IN_W{1'b0}}, b}  << la);
        m = {{IN_W{1'b0}}, ma} | ({{IN_W{1'b0}}, mb} << la);
    end
endmodule

// File: rtl/kx_key_builder.sv
// Builds one key from four configured slots. Four field selectors feed two
// first-level resizers, and one second-level resizer joins their outputs.
// Purely combinational.
module kx_key_builder
    import kx_pkg::*;
#(
    parameter int FLD_W = 32,
    parameter int SLOTS = 4
) (
    input  logic [PHV_W-1:0]       phv,
    input  fld_cfg_t               cfg [SLOTS],
    output logic [SLOTS*FLD_W-1:0] key,
    output logic [SLOTS*FLD_W-1:0] mask
);
    localparam int PAIRS = SLOTS / 2;

    logic [FLD_W-1:0]   fld   [SLOTS];
    logic [FLD_W-1:0]   fmsk  [SLOTS];
    logic [LEN_W-1:0]   flen  [SLOTS];
    logic [2*FLD_W-1:0] pkey  [PAIRS];
    logic [2*FLD_W-1:0] pmsk  [PAIRS];
    logic [LEN_W:0]     low_len;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        kx_field_select #(.FLD_W(FLD_W)) u_sel (
            .phv   (phv),
            .cfg   (cfg[s]),
            .fld   (fld[s]),
            .fmask (fmsk[s]),
            .flen  (flen[s])
        );
    end

    for (genvar p = 0; p < PAIRS; p++) begin : g_lvl1
        kx_resizer #(.IN_W(FLD_W), .SH_W(LEN_W)) u_rs (
            .a  (fld[2*p]),
            .ma (fmsk[2*p]),
            .la (flen[2*p]),
            .b  (fld[2*p+1]),
            .mb (fmsk[2*p+1]),
            .y  (pkey[p]),
            .m  (pmsk[p])
        );
    end

    // Length of the lower pair sets the second-level shift.
    always_comb low_len = {1'b0, flen[0]} + {1'b0, flen[1]};

    kx_resizer #(.IN_W(2*FLD_W), .SH_W(LEN_W+1)) u_rs_top (
        .a  (pkey[0]),
        .ma (pmsk[0]),
        .la (low_len),
        .b  (pkey[1]),
        .mb (pmsk[1]),
        .y  (key),
        .m  (mask)
    );
endmodule

// File: rtl/kx_key_extractor.sv
// Stage key extractor. Holds the per-slot configuration for the exact and
// ternary keys, builds both keys from the header vector, and registers them
// one cycle after the strobe. Keys hold their value while the strobe is idle.
// Assumes configuration is written while no header vector is in the same cycle.
module kx_key_extractor
    import kx_pkg::*;
#(
    parameter int FLD_W = 32,
    parameter int KEYS  = 2,
    parameter int SLOTS = 4,
    localparam int KEY_W = SLOTS * FLD_W,
    localparam int SLT_W = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phv_valid,
    input  logic [PHV_W-1:0]   phv_data,
    input  logic               cfg_wr,
    input  logic               cfg_key,
    input  logic [SLT_W-1:0]   cfg_slot,
    input  logic [CFG_W-1:0]   cfg_field,
    output logic [KEY_W-1:0]   em_key,
    output logic [KEY_W-1:0]   em_mask,
    output logic               em_valid,
    output logic [KEY_W-1:0]   tc_key,
    output logic [KEY_W-1:0]   tc_mask,
    output logic               tc_valid
);
    fld_cfg_t         cfg_q  [KEYS][SLOTS];
    logic [KEY_W-1:0] key_c  [KEYS];
    logic [KEY_W-1:0] mask_c [KEYS];
    logic [KEY_W-1:0] key_q  [KEYS];
    logic [KEY_W-1:0] mask_q [KEYS];
    logic             valid_q;

    // Slot configuration storage; reset disables every slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < KEYS; k++)
                for (int s = 0; s < SLOTS; s++)
                    cfg_q[k][s] <= '0;
        end else if (cfg_wr) begin
            cfg_q[cfg_key][cfg_slot] <= fld_cfg_t'(cfg_field);
        end
    end

    for (genvar k = 0; k < KEYS; k++) begin : g_key
        kx_key_builder #(.FLD_W(FLD_W), .SLOTS(SLOTS)) u_bld (
            .phv  (phv_data),
            .cfg  (cfg_q[k]),
            .key  (key_c[k]),
            .mask (mask_c[k])
        );

        // Output register for this key; loads only with the strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_q[k]  <= '0;
                mask_q[k] <= '0;
            end else if (phv_valid) begin
                key_q[k]  <= key_c[k];
                mask_q[k] <= mask_c[k];
            end
        end
    end

    // Valid flag follows the strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= phv_valid;
    end

    assign em_key   = key_q[0];
    assign em_mask  = mask_q[0];
    assign em_valid = valid_q;
    assign tc_key   = key_q[1];
    assign tc_mask  = mask_q[1];
    assign tc_valid = valid_q;
endmodule

// File: rtl/kx_key_extractor_chk.sv
// Property checker for the key extractor, attached with bind.
module kx_key_extractor_chk #(
    parameter int KEY_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phv_valid,
    input logic [KEY_W-1:0] em_key,
    input logic [KEY_W-1:0] em_mask,
    input logic             em_valid,
    input logic [KEY_W-1:0] tc_key,
    input logic [KEY_W-1:0] tc_mask,
    input logic             tc_valid
);
    p_valid_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phv_valid |=> (em_valid && tc_valid));

    p_valid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !phv_valid |=> (!em_valid && !tc_valid));

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !phv_valid |=> ($stable(em_key) && $stable(em_mask) && $stable(tc_key) && $stable(tc_mask)));

    p_mask_packed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((em_mask & (em_mask + 1'b1)) == '0) && ((tc_mask & (tc_mask + 1'b1)) == '0));

    p_key_within_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((em_key & ~em_mask) == '0) && ((tc_key & ~tc_mask) == '0));
endmodule

bind kx_key_extractor kx_key_extractor_chk #(.KEY_W(KEY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phv_valid (phv_valid),
    .em_key    (em_key),
    .em_mask   (em_mask),
    .em_valid  (em_valid),
    .tc_key    (tc_key),
    .tc_mask   (tc_mask),
    .tc_valid  (tc_valid)
);

// File: tb/kx_key_extractor_tb_top.sv
// Bench: bit-by-bit reference model, compared with the outputs every cycle.
module kx_key_extractor_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         phv_valid;
    logic [511:0] phv_data;
    logic         cfg_wr;
    logic         cfg_key;
    logic [1:0]   cfg_slot;
    logic [16:0]  cfg_field;
    logic [127:0] em_key, em_mask, tc_key, tc_mask;
    logic         em_valid, tc_valid;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string phase  = "R8";

    logic [16:0]  mcfg [2][4];
    logic [127:0] xkey [2];
    logic [127:0] xmsk [2];
    logic         xval;

    always #5 clk = ~clk;

    kx_key_extractor dut_i (
        .clk(clk), .rst_n(rst_n), .phv_valid(phv_valid), .phv_data(phv_data),
        .cfg_wr(cfg_wr), .cfg_key(cfg_key), .cfg_slot(cfg_slot), .cfg_field(cfg_field),
        .em_key(em_key), .em_mask(em_mask), .em_valid(em_valid),
        .tc_key(tc_key), .tc_mask(tc_mask), .tc_valid(tc_valid)
    );

    // Reference: walk every requested bit and append it if it is inside the container.
    function automatic void ref_key(input logic [511:0] p, input int k,
                                    output logic [127:0] key, output logic [127:0] msk);
        int pos, typ, idx, st, ln, base, w;
        key = '0; msk = '0; pos = 0;
        for (int s = 0; s < 4; s++) begin
            typ = int'(mcfg[k][s][16:15]);
            idx = int'(mcfg[k][s][14:12]);
            st  = int'(mcfg[k][s][11:6]);
            ln  = int'(mcfg[k][s][5:0]);
            if (ln > 32) ln = 32;
            case (typ)
                0:       begin base = idx * 8;         w = 8;  end
                1:       begin base = 64 + idx * 16;   w = 16; end
                2:       begin base = 192 + idx * 32;  w = 32; end
                default: begin base = 448;             w = 64; end
            endcase
            for (int b = 0; b < ln; b++) begin
                if (st + b < w) begin
                    key[pos] = p[base + st + b];
                    msk[pos] = 1'b1;
                    pos++;
                end
            end
        end
    endfunction

    // Model state update at the active edge.
    always @(posedge clk) begin
        logic [127:0] tk, tm;
        if (!rst_n) begin
            xval <= 1'b0;
            for (int k = 0; k < 2; k++) begin
                xkey[k] <= '0; xmsk[k] <= '0;
                for (int s = 0; s < 4; s++) mcfg[k][s] <= '0;
            end
        end else begin
            xval <= phv_valid;
            if (phv_valid) begin
                for (int k = 0; k < 2; k++) begin
                    ref_key(phv_data, k, tk, tm);
                    xkey[k] <= tk; xmsk[k] <= tm;
                end
            end
            if (cfg_wr) mcfg[cfg_key][cfg_slot] <= cfg_field;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (!done && n_chk < 100000) begin
            check(phase, "em_key",   em_key,   xkey[0]);
            check(phase, "em_mask",  em_mask,  xmsk[0]);
            check(phase, "tc_key",   tc_key,   xkey[1]);
            check(phase, "tc_mask",  tc_mask,  xmsk[1]);
            check(phase, "em_valid", 128'(em_valid), 128'(xval));
            check(phase, "tc_valid", 128'(tc_valid), 128'(xval));
        end
    end

    task automatic wcfg(input bit k, input int s, input int typ, input int idx,
                        input int st, input int ln);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_key = k; cfg_slot = 2'(s);
        cfg_field = {2'(typ), 3'(idx), 6'(st), 6'(ln)};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [511:0] rnd_phv();
        logic [511:0] p;
        for (int i = 0; i < 16; i++) p[i*32 +: 32] = $urandom;
        return p;
    endfunction

    task automatic send(input int n, input bit rnd_valid);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            phv_data  = rnd_phv();
            phv_valid = rnd_valid ? 1'($urandom % 2) : 1'b1;
        end
        @(negedge clk);
        phv_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; phv_valid = 1'b0; phv_data = '0;
        cfg_wr = 1'b0; cfg_key = 1'b0; cfg_slot = '0; cfg_field = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state, explicit check
        @(negedge clk);
        check("R8", "reset em_mask", em_mask, '0);
        check("R8", "reset tc_valid", 128'(tc_valid), '0);

        phase = "R6";   // all slots disabled: zero key, zero mask
        send(3, 1'b0);
        @(negedge clk);
        check("R6", "empty em_mask", em_mask, '0);

        phase = "R1";   // one slot per container type, layout check
        wcfg(0, 0, 0, 5, 0, 8);
        wcfg(1, 0, 3, 0, 0, 32);
        send(3, 1'b0);
        wcfg(0, 0, 1, 6, 0, 16);
        wcfg(1, 0, 2, 2, 0, 32);
        send(3, 1'b0);

        phase = "R4";   // sub-field cuts with an empty slot in between
        wcfg(0, 0, 1, 3, 4, 8);
        wcfg(0, 1, 0, 0, 0, 0);
        wcfg(0, 2, 2, 7, 0, 32);
        wcfg(0, 3, 0, 5, 2, 5);
        send(20, 1'b0);

        phase = "R7";   // clamping and truncation at container edges
        wcfg(1, 0, 3, 0, 40, 32);
        wcfg(1, 1, 0, 0, 9, 3);
        wcfg(1, 2, 2, 0, 20, 40);
        wcfg(1, 3, 1, 7, 0, 63);
        send(20, 1'b0);

        phase = "R9";   // random strobe, holds while idle
        send(60, 1'b1);

        phase = "R5";   // full-width key and four byte fields
        for (int s = 0; s < 4; s++) wcfg(0, s, 2, s + 2, 0, 32);
        for (int s = 0; s < 4; s++) wcfg(1, s, 0, 7 - s, 0, 8);
        send(10, 1'b0);
        @(negedge clk);
        check("R5", "full em_mask", em_mask, {128{1'b1}});
        check("R5", "byte tc_mask", tc_mask, 128'hFFFF_FFFF);

        phase = "R10";  // rewrite one exact slot only
        wcfg(0, 1, 3, 0, 60, 10);
        send(10, 1'b0);
        @(negedge clk);
        check("R10", "tc_mask untouched", tc_mask, 128'hFFFF_FFFF);

        phase = "R2";   // header vector right after a write uses it
        @(negedge clk);
        cfg_wr = 1'b1; cfg_key = 1'b1; cfg_slot = 2'd0; cfg_field = {2'd1, 3'd1, 6'd0, 6'd4};
        @(negedge clk);
        cfg_wr = 1'b0; phv_data = rnd_phv(); phv_valid = 1'b1;
        @(negedge clk);
        phv_valid = 1'b0;
        check("R2", "tc_mask after write", tc_mask, 128'h0FFF_FFFF);

        phase = "R3";   // single strobe, valid for one cycle only
        send(1, 1'b0);
        repeat (3) @(negedge clk);
        check("R3", "valid low after pulse", 128'(em_valid), '0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule